// File: doc/BRIEF.md
# Command-Port DMA Channel Programmer

This block is the register front end of a sixteen-channel DMA engine. Software reaches it through two byte-wide ports. A byte written to the command port selects an operation and a channel. The execute port then moves the parameter bytes for that operation, one byte per access, under an internal byte pointer.

Each channel keeps five pieces of state: a 24-bit memory address, a 16-bit transfer count, a 16-bit I/O port number, a mode byte and a mask bit. These are driven out continuously, together with a per-channel enable (the inverse of the mask) and decoded mode flags, to the data mover that sits beside this block. Software normally programs a channel in this order: mask it, set the mode, load the address, load the count, then unmask it.

Top module: `dma_cmd_regs`

## Requirements
- R1: A command-port byte carries the opcode in bits 7..4 and the channel number in bits 3..0. Later execute-port accesses act only on that channel.
- R2: After reset every channel is masked (its enable is 0), and its address, count, port number and mode are all zero.
- R3: Opcode 0x0 loads the 16-bit I/O port number through two execute-port writes, low byte first.
- R4: Opcode 0x2 loads the 24-bit address through three execute writes, in the order bits 7..0, 15..8, 23..16. Opcode 0x3 returns the address on execute reads in that same order.
- R5: Opcode 0x4 loads the 16-bit count (transfer units minus one) through two execute writes, low byte first. Opcode 0x5 returns it on two execute reads, low byte first.
- R6: Opcode 0x7 loads the mode byte through one execute write. Its bits decode as: bit 2 = perform transfer, bit 3 = read (1) or write (0), bit 0 = I/O-port target, bit 6 = 16-bit units. Each decoded bit appears on its own per-channel output.
- R7: Opcode 0x9 masks the selected channel, which drives its enable to 0. Opcode 0xA unmasks it, which drives its enable to 1. The other channels are left as they were.
- R8: Every command-port write resets the byte pointer to zero, so a load that was cut short and then restarted begins again at the low byte.
- R9: Execute-port accesses beyond the last byte of the current opcode are ignored. They change no state, and a read there returns 0x00.
- R10: An execute read under an opcode that is not a get returns 0x00. An execute write under a get opcode changes no state.
- R11: Opcodes other than 0x0, 0x2, 0x3, 0x4, 0x5, 0x7, 0x9 and 0xA are accepted but leave all channel state unchanged, including any execute writes that follow them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_we_i | input | 1 | Command-port write strobe |
| cmd_data_i | input | 8 | Command byte: opcode in bits 7..4, channel in bits 3..0 |
| exe_we_i | input | 1 | Execute-port write strobe |
| exe_re_i | input | 1 | Execute-port read strobe |
| exe_wdata_i | input | 8 | Execute-port write byte |
| exe_rdata_o | output | 8 | Execute-port read byte, valid while exe_re_i is high |
| ch_en_o | output | NCH | Per-channel enable (not masked) |
| ch_addr_o | output | NCH*24 | Channel addresses, channel i at bits i*24 and up |
| ch_cnt_o | output | NCH*16 | Channel counts (units minus one) |
| ch_port_o | output | NCH*16 | Channel I/O port numbers |
| ch_mode_o | output | NCH*8 | Raw channel mode bytes |
| ch_xfer_o | output | NCH | Mode bit 2: perform transfer |
| ch_read_o | output | NCH | Mode bit 3: read direction |
| ch_to_io_o | output | NCH | Mode bit 0: I/O-port target |
| ch_wide_o | output | NCH | Mode bit 6: 16-bit units |

## Verification
The assertions take for granted that at most one of the three port strobes is high in any cycle. Without that, a command and an execute access landing on the same edge would have no defined order. The stability properties also rely on this, because they compare channel state across a single edge at which only the strobe under test acts. The bench's port tasks each raise exactly one strobe for one cycle and drop it before the next task starts, so the stimulus never leaves that assumption.

// File: rtl/dma_cmd_pkg.sv
package dma_cmd_pkg;
  localparam int ADDR_W = 24;
  localparam int CNT_W  = 16;
  localparam int PORT_W = 16;
  localparam int MODE_W = 8;

  localparam logic [3:0] OP_SET_PORT = 4'h0;
  localparam logic [3:0] OP_SET_ADDR = 4'h2;
  localparam logic [3:0] OP_GET_ADDR = 4'h3;
  localparam logic [3:0] OP_SET_CNT  = 4'h4;
  localparam logic [3:0] OP_GET_CNT  = 4'h5;
  localparam logic [3:0] OP_SET_MODE = 4'h7;
  localparam logic [3:0] OP_MASK     = 4'h9;
  localparam logic [3:0] OP_UNMASK   = 4'hA;
  localparam logic [3:0] OP_IDLE     = 4'hF;

  localparam int MB_TO_IO = 0;
  localparam int MB_XFER  = 2;
  localparam int MB_READ  = 3;
  localparam int MB_WIDE  = 6;

  function automatic logic [1:0] op_len(logic [3:0] op);
    case (op)
      OP_SET_ADDR, OP_GET_ADDR:            return 2'd3;
      OP_SET_PORT, OP_SET_CNT, OP_GET_CNT: return 2'd2;
      OP_SET_MODE:                         return 2'd1;
      default:                             return 2'd0;
    endcase
  endfunction

  function automatic logic op_is_set(logic [3:0] op);
    return op == OP_SET_PORT || op == OP_SET_ADDR || op == OP_SET_CNT || op == OP_SET_MODE;
  endfunction

  function automatic logic op_is_get(logic [3:0] op);
    return op == OP_GET_ADDR || op == OP_GET_CNT;
  endfunction

  function automatic logic op_known(logic [3:0] op);
    return op_is_set(op) || op_is_get(op) || op == OP_MASK || op == OP_UNMASK;
  endfunction
endpackage

// File: rtl/dma_cmd_decode.sv
module dma_cmd_decode
  import dma_cmd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_we_i,
  input  logic [7:0] cmd_data_i,
  input  logic       exe_we_i,
  input  logic       exe_re_i,
  output logic [3:0] op_o,
  output logic [3:0] chan_o,
  output logic [1:0] ptr_o,
  output logic       wr_en_o,
  output logic       rd_en_o,
  output logic       mask_set_o,
  output logic       mask_clr_o
);
  logic [3:0] op_q, chan_q;
  logic [1:0] ptr_q;
  logic       in_range;

  assign in_range   = ptr_q < op_len(op_q);
  assign wr_en_o    = exe_we_i && op_is_set(op_q) && in_range;
  assign rd_en_o    = exe_re_i && op_is_get(op_q) && in_range;
  // mask changes act on the channel named in the command byte itself
  assign mask_set_o = cmd_we_i && cmd_data_i[7:4] == OP_MASK;
  assign mask_clr_o = cmd_we_i && cmd_data_i[7:4] == OP_UNMASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q   <= OP_IDLE;
      chan_q <= '0;
      ptr_q  <= '0;
    end else if (cmd_we_i) begin
      op_q   <= cmd_data_i[7:4];
      chan_q <= cmd_data_i[3:0];
      ptr_q  <= '0;
    end else if (wr_en_o || rd_en_o) begin
      ptr_q  <= ptr_q + 2'd1;
    end
  end

  assign op_o   = op_q;
  assign chan_o = chan_q;
  assign ptr_o  = ptr_q;
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_cmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [3:0]        op_i,
  input  logic [1:0]        ptr_i,
  input  logic [7:0]        wdata_i,
  input  logic              mask_set_i,
  input  logic              mask_clr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [PORT_W-1:0] port_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              masked_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o   <= '0;
      cnt_o    <= '0;
      port_o   <= '0;
      mode_o   <= '0;
      masked_o <= 1'b1;
    end else begin
      if (mask_set_i)      masked_o <= 1'b1;
      else if (mask_clr_i) masked_o <= 1'b0;
      if (wr_i) begin
        case (op_i)
          OP_SET_PORT:
            if (ptr_i[0]) port_o[15:8] <= wdata_i;
            else          port_o[7:0]  <= wdata_i;
          OP_SET_CNT:
            if (ptr_i[0]) cnt_o[15:8] <= wdata_i;
            else          cnt_o[7:0]  <= wdata_i;
          OP_SET_ADDR:
            case (ptr_i)
              2'd0:    addr_o[7:0]   <= wdata_i;
              2'd1:    addr_o[15:8]  <= wdata_i;
              default: addr_o[23:16] <= wdata_i;
            endcase
          OP_SET_MODE: mode_o <= wdata_i;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/dma_rd_mux.sv
module dma_rd_mux
  import dma_cmd_pkg::*;
(
  input  logic              rd_en_i,
  input  logic [3:0]        op_i,
  input  logic [1:0]        ptr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [7:0]        rdata_o
);
  always_comb begin
    rdata_o = 8'h00;
    if (rd_en_i) begin
      if (op_i == OP_GET_ADDR) begin
        case (ptr_i)
          2'd0:    rdata_o = addr_i[7:0];
          2'd1:    rdata_o = addr_i[15:8];
          default: rdata_o = addr_i[23:16];
        endcase
      end else begin
        rdata_o = ptr_i[0] ? cnt_i[15:8] : cnt_i[7:0];
      end
    end
  end
endmodule

// File: rtl/dma_cmd_regs.sv
module dma_cmd_regs
  import dma_cmd_pkg::*;
#(
  parameter int NCH = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cmd_we_i,
  input  logic [7:0]              cmd_data_i,
  input  logic                    exe_we_i,
  input  logic                    exe_re_i,
  input  logic [7:0]              exe_wdata_i,
  output logic [7:0]              exe_rdata_o,
  output logic [NCH-1:0]          ch_en_o,
  output logic [NCH*ADDR_W-1:0]   ch_addr_o,
  output logic [NCH*CNT_W-1:0]    ch_cnt_o,
  output logic [NCH*PORT_W-1:0]   ch_port_o,
  output logic [NCH*MODE_W-1:0]   ch_mode_o,
  output logic [NCH-1:0]          ch_xfer_o,
  output logic [NCH-1:0]          ch_read_o,
  output logic [NCH-1:0]          ch_to_io_o,
  output logic [NCH-1:0]          ch_wide_o
);
  logic [3:0] op, chan;
  logic [1:0] ptr;
  logic       wr_en, rd_en, mask_set, mask_clr;

  logic [ADDR_W-1:0] addr_arr [NCH];
  logic [CNT_W-1:0]  cnt_arr  [NCH];
  logic [ADDR_W-1:0] sel_addr;
  logic [CNT_W-1:0]  sel_cnt;

  dma_cmd_decode u_dec (
    .clk_i, .rst_ni, .cmd_we_i, .cmd_data_i, .exe_we_i, .exe_re_i,
    .op_o(op), .chan_o(chan), .ptr_o(ptr), .wr_en_o(wr_en), .rd_en_o(rd_en),
    .mask_set_o(mask_set), .mask_clr_o(mask_clr)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [MODE_W-1:0] mode;
    logic              masked;
    logic              hit_exe, hit_cmd;

    assign hit_exe = chan == 4'(i);
    assign hit_cmd = cmd_data_i[3:0] == 4'(i);

    dma_chan_regs u_ch (
      .clk_i, .rst_ni,
      .wr_i       (wr_en && hit_exe),
      .op_i       (op),
      .ptr_i      (ptr),
      .wdata_i    (exe_wdata_i),
      .mask_set_i (mask_set && hit_cmd),
      .mask_clr_i (mask_clr && hit_cmd),
      .addr_o     (addr_arr[i]),
      .cnt_o      (cnt_arr[i]),
      .port_o     (ch_port_o[i*PORT_W +: PORT_W]),
      .mode_o     (mode),
      .masked_o   (masked)
    );

    assign ch_addr_o[i*ADDR_W +: ADDR_W] = addr_arr[i];
    assign ch_cnt_o[i*CNT_W +: CNT_W]    = cnt_arr[i];
    assign ch_mode_o[i*MODE_W +: MODE_W] = mode;
    assign ch_en_o[i]    = !masked;
    assign ch_xfer_o[i]  = mode[MB_XFER];
    assign ch_read_o[i]  = mode[MB_READ];
    assign ch_to_io_o[i] = mode[MB_TO_IO];
    assign ch_wide_o[i]  = mode[MB_WIDE];
  end

  always_comb begin
    sel_addr = '0;
    sel_cnt  = '0;
    for (int i = 0; i < NCH; i++) begin
      if (chan == 4'(i)) begin
        sel_addr = addr_arr[i];
        sel_cnt  = cnt_arr[i];
      end
    end
  end

  dma_rd_mux u_rd (
    .rd_en_i(rd_en), .op_i(op), .ptr_i(ptr),
    .addr_i(sel_addr), .cnt_i(sel_cnt), .rdata_o(exe_rdata_o)
  );
endmodule

// File: rtl/dma_cmd_regs_chk.sv
module dma_cmd_regs_chk
  import dma_cmd_pkg::*;
#(
  parameter int NCH = 16
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  cmd_we_i,
  input logic [7:0]            cmd_data_i,
  input logic                  exe_we_i,
  input logic                  exe_re_i,
  input logic [7:0]            exe_rdata_i,
  input logic [3:0]            cur_op_i,
  input logic [1:0]            ptr_i,
  input logic [NCH-1:0]        en_i,
  input logic [NCH*ADDR_W-1:0] addr_i,
  input logic [NCH*CNT_W-1:0]  cnt_i,
  input logic [NCH*PORT_W-1:0] port_i,
  input logic [NCH*MODE_W-1:0] mode_i
);
  logic [3:0] last_ch;
  logic [NCH*(1+ADDR_W+CNT_W+PORT_W+MODE_W)-1:0] state;
  assign state = {en_i, addr_i, cnt_i, port_i, mode_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       last_ch <= '0;
    else if (cmd_we_i) last_ch <= cmd_data_i[3:0];
  end

  assert_one_strobe_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cmd_we_i, exe_we_i, exe_re_i}));

  assert_mask_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_we_i && cmd_data_i[7:4] == OP_MASK && int'(cmd_data_i[3:0]) < NCH
    |=> !en_i[last_ch]);

  assert_unmask_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_we_i && cmd_data_i[7:4] == OP_UNMASK && int'(cmd_data_i[3:0]) < NCH
    |=> en_i[last_ch]);

  assert_ptr_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_we_i |=> ptr_i == 2'd0);

  assert_overrun_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exe_we_i && ptr_i == op_len(cur_op_i) |=> $stable(state));

  assert_get_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exe_we_i && op_is_get(cur_op_i) |=> $stable(state));

  assert_rd_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exe_re_i && !op_is_get(cur_op_i) |-> exe_rdata_i == 8'h00);

  assert_unknown_op_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_we_i && !op_known(cmd_data_i[7:4]) |=> $stable(state));
endmodule

bind dma_cmd_regs dma_cmd_regs_chk #(.NCH(NCH)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cmd_we_i   (cmd_we_i),
  .cmd_data_i (cmd_data_i),
  .exe_we_i   (exe_we_i),
  .exe_re_i   (exe_re_i),
  .exe_rdata_i(exe_rdata_o),
  .cur_op_i   (op),
  .ptr_i      (ptr),
  .en_i       (ch_en_o),
  .addr_i     (ch_addr_o),
  .cnt_i      (ch_cnt_o),
  .port_i     (ch_port_o),
  .mode_i     (ch_mode_o)
);

// File: tb/dma_cmd_regs_tb.sv
module dma_cmd_regs_tb_top;
  localparam int NCH = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cmd_we = 1'b0, exe_we = 1'b0, exe_re = 1'b0;
  logic [7:0]        cmd_data = '0, exe_wdata = '0, exe_rdata;
  logic [NCH-1:0]    en, xfer, rd, to_io, wide;
  logic [NCH*24-1:0] addr;
  logic [NCH*16-1:0] cnt, port;
  logic [NCH*8-1:0]  mode;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dma_cmd_regs #(.NCH(NCH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cmd_we_i(cmd_we), .cmd_data_i(cmd_data),
    .exe_we_i(exe_we), .exe_re_i(exe_re), .exe_wdata_i(exe_wdata),
    .exe_rdata_o(exe_rdata), .ch_en_o(en), .ch_addr_o(addr), .ch_cnt_o(cnt),
    .ch_port_o(port), .ch_mode_o(mode), .ch_xfer_o(xfer), .ch_read_o(rd),
    .ch_to_io_o(to_io), .ch_wide_o(wide)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cmd_wr(logic [7:0] b);
    @(negedge clk); cmd_we = 1'b1; cmd_data = b;
    @(negedge clk); cmd_we = 1'b0;
  endtask

  task automatic exe_wr(logic [7:0] b);
    @(negedge clk); exe_we = 1'b1; exe_wdata = b;
    @(negedge clk); exe_we = 1'b0;
  endtask

  task automatic exe_rd(output logic [7:0] b);
    @(negedge clk); exe_re = 1'b1;
    #1 b = exe_rdata;
    @(negedge clk); exe_re = 1'b0;
  endtask

  function automatic logic [23:0] a_of(int ch); return addr[ch*24 +: 24]; endfunction
  function automatic logic [15:0] c_of(int ch); return cnt[ch*16 +: 16];  endfunction
  function automatic logic [15:0] p_of(int ch); return port[ch*16 +: 16]; endfunction

  task automatic t_reset();
    logic [7:0] b;
    chk("R2 enables", en, 0);
    chk("R2 addr ch0", a_of(0), 0);
    chk("R2 mode all", mode[31:0], 0);
    cmd_wr(8'h35);
    for (int k = 0; k < 3; k++) begin
      exe_rd(b);
      chk("R2 addr readback", b, 0);
    end
  endtask

  task automatic t_program();
    cmd_wr(8'h93);
    cmd_wr(8'h73); exe_wr(8'h4D);
    cmd_wr(8'h23); exe_wr(8'h56); exe_wr(8'h34); exe_wr(8'h12);
    cmd_wr(8'h43); exe_wr(8'hFF); exe_wr(8'h01);
    cmd_wr(8'hA3);
    chk("R7 unmask ch3 only", en, 32'h0008);
    chk("R4 addr ch3", a_of(3), 32'h123456);
    chk("R1 addr ch2 untouched", a_of(2), 0);
    chk("R1 addr ch4 untouched", a_of(4), 0);
    chk("R5 count ch3", c_of(3), 32'h01FF);
    chk("R6 mode flags ch3", {xfer[3], rd[3], to_io[3], wide[3]}, 4'b1111);
  endtask

  task automatic t_port();
    cmd_wr(8'h07); exe_wr(8'hCD); exe_wr(8'hAB);
    chk("R3 port ch7", p_of(7), 32'hABCD);
    chk("R3 port ch3 untouched", p_of(3), 0);
  endtask

  task automatic t_readback();
    logic [7:0] b;
    cmd_wr(8'h33);
    exe_rd(b); chk("R4 read byte0", b, 8'h56);
    exe_rd(b); chk("R4 read byte1", b, 8'h34);
    exe_rd(b); chk("R4 read byte2", b, 8'h12);
    exe_rd(b); chk("R9 read past end", b, 8'h00);
    cmd_wr(8'h53);
    exe_rd(b); chk("R5 read low", b, 8'hFF);
    exe_rd(b); chk("R5 read high", b, 8'h01);
  endtask

  task automatic t_overrun();
    cmd_wr(8'h47); exe_wr(8'h11); exe_wr(8'h22); exe_wr(8'h33);
    chk("R9 extra write ignored", c_of(7), 32'h2211);
    chk("R9 port ch7 kept", p_of(7), 32'hABCD);
  endtask

  task automatic t_restart();
    cmd_wr(8'h2A); exe_wr(8'hAA);
    chk("R8 partial load", a_of(10), 32'h0000AA);
    cmd_wr(8'h2A); exe_wr(8'h01);
    chk("R8 pointer reset", a_of(10), 32'h000001);
    exe_wr(8'h02); exe_wr(8'h03);
    chk("R8 restarted load", a_of(10), 32'h030201);
  endtask

  task automatic t_ignored();
    logic [7:0] b;
    cmd_wr(8'hB3); exe_wr(8'h77);
    cmd_wr(8'hF3); exe_wr(8'h88);
    cmd_wr(8'h13); exe_wr(8'h99);
    cmd_wr(8'h63); exe_wr(8'h55);
    chk("R11 addr ch3 kept", a_of(3), 32'h123456);
    chk("R11 count ch3 kept", c_of(3), 32'h01FF);
    chk("R11 port ch3 kept", p_of(3), 0);
    chk("R11 mode ch3 kept", mode[3*8 +: 8], 8'h4D);
    chk("R11 enables kept", en, 32'h0008);
    cmd_wr(8'h33); exe_wr(8'hEE);
    chk("R10 write under get", a_of(3), 32'h123456);
    cmd_wr(8'h23); exe_rd(b);
    chk("R10 read under set", b, 8'h00);
    chk("R10 addr after read", a_of(3), 32'h123456);
  endtask

  task automatic t_mode_mask();
    cmd_wr(8'h71); exe_wr(8'h04);
    chk("R6 mode flags ch1", {xfer[1], rd[1], to_io[1], wide[1]}, 4'b1000);
    cmd_wr(8'hA1);
    chk("R7 unmask ch1", en, 32'h000A);
    cmd_wr(8'h93);
    chk("R7 mask ch3", en, 32'h0002);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_program();
    t_port();
    t_readback();
    t_overrun();
    t_restart();
    t_ignored();
    t_mode_mask();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule